// File: doc/BRIEF.md
# Bit-Granular Serial Time-Slot Router

This block sits between a framed serial line and an internal serial controller. It derives a bit clock at half the rate of its input clock. It counts bit positions inside each frame, restarting at a frame sync pulse and wrapping at a programmable last position. A per-position enable map decides which positions belong to the controller. Selecting single bits this way lets a low-rate sub-channel be carved out of the frame one bit at a time.

Receive data is sampled in the second half of each bit. On an enabled position it is handed to the controller as a one-cycle strobe with the bit value. For transmit, the block raises a strobe in the first half of each enabled position and takes the controller's bit in that cycle. It then pulls the open-drain line low if the bit is 0 and otherwise leaves it released. On a position that is not enabled it always leaves the line released.

A mode input makes the transmit side follow the receive frame sync, so that both directions share one bus timing. Map writes go to a staging copy, and each direction adopts that copy only at its own frame boundary.

Top module: `bit_slot_router`

## Requirements
- R1: During and after reset, `rx_stb_o`, `tx_stb_o` and `txd_oe_o` are 0, and the enable map is all zero, so a frame produces no strobes until the map is written.
- R2: One bit lasts two input-clock cycles. If `rx_fs_i` is high in cycle t, bit k is sampled from `rxd_i` in cycle t+2+2k.
- R3: For each sampled bit whose map entry (map bit index = bit position) is 1, `rx_stb_o` is high for exactly the next cycle, with `rx_bit_o` equal to the sampled value. Disabled positions give no strobe.
- R4: `tx_stb_o` is high in the first cycle of each enabled transmit position (cycle t+1+2k after a transmit sync in cycle t) and low in every other cycle.
- R5: `txd_o` is always 0, and `txd_oe_o` = 1 means the line is driven low. `tx_bit_i` is captured in the strobe cycle. `txd_oe_o` is then 1 for the following two cycles only if that bit was 0, and is 0 across disabled positions.
- R6: After position `frame_last_i` the count wraps to 0 without a sync, so the frame repeats every 2*(`frame_last_i`+1) cycles.
- R7: A sync pulse in the middle of a frame restarts the count at position 0 on the following cycle.
- R8: A map write (`map_we_i`, `map_addr_i`, `map_bit_i`) does not affect the frame in progress. It takes effect from the next frame boundary, which is either a sync or a wrap.
- R9: With `share_timing_i` = 1 the transmit side is framed by `rx_fs_i`, and `tx_fs_i` has no effect. With 0 it is framed by `tx_fs_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_last_i | input | $clog2(MAX_BITS) | Index of the last bit position in a frame |
| share_timing_i | input | 1 | 1: transmit side uses the receive sync |
| rx_fs_i | input | 1 | Receive frame sync pulse |
| tx_fs_i | input | 1 | Transmit frame sync pulse |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Open-drain data value, constant 0 |
| txd_oe_o | output | 1 | Open-drain output enable (1 = pull low) |
| map_we_i | input | 1 | Enable map write strobe |
| map_addr_i | input | $clog2(MAX_BITS) | Bit position to write |
| map_bit_i | input | 1 | New enable for that position |
| rx_stb_o | output | 1 | Received-bit strobe to the controller |
| rx_bit_o | output | 1 | Received bit value |
| tx_stb_o | output | 1 | Transmit-bit request to the controller |
| tx_bit_i | input | 1 | Transmit bit value, valid while tx_stb_o is high |

## Verification
The hardest case to reach is a map write that lands in the middle of a frame. The rule is that the running frame keeps its old selection and the next one, started by a wrap and not by a sync, uses the new one. The bench reaches it by starting a frame with a sync, letting the frame wrap on its own, and writing a single map entry a few cycles into the first frame. It then checks every strobe of that frame against the old map and every strobe of the later frames against the new one. A second situation is a separate transmit sync one cycle behind the receive sync. There the bench tracks the two directions on independent timelines to show that the mode input chooses which pulse frames the transmitter.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/bsr_framer.sv
module bsr_framer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             boundary_o
);
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last    = (cnt_q == last_i);
  assign tick_o     = phase_q;
  assign idx_o      = cnt_q;
  assign boundary_o = sync_i | (phase_q & at_last);

  always_comb begin
    phase_d = ~phase_q;
    cnt_d   = cnt_q;
    if (phase_q) cnt_d = at_last ? '0 : cnt_q + 1'b1;
    if (sync_i) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bsr_map_stage.sv
module bsr_map_stage #(
  parameter int BITS = 32,
  localparam int AW  = $clog2(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            bit_i,
  output logic [BITS-1:0] map_o
);
  logic [BITS-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (we_i) map_d[addr_i] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end

  assign map_o = map_q;
endmodule

// File: rtl/bsr_map_active.sv
module bsr_map_active #(
  parameter int BITS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] staged_i,
  output logic [BITS-1:0] map_o
);
  logic [BITS-1:0] map_q, map_d;

  always_comb map_d = load_i ? staged_i : map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end

  assign map_o = map_q;
endmodule

// File: rtl/bit_slot_router.sv
module bit_slot_router
  import bsr_pkg::*;
#(
  parameter int MAX_BITS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [$clog2(MAX_BITS)-1:0] frame_last_i,
  input  logic                        share_timing_i,
  input  logic                        rx_fs_i,
  input  logic                        tx_fs_i,
  input  logic                        rxd_i,
  output logic                        txd_o,
  output logic                        txd_oe_o,
  input  logic                        map_we_i,
  input  logic [$clog2(MAX_BITS)-1:0] map_addr_i,
  input  logic                        map_bit_i,
  output logic                        rx_stb_o,
  output logic                        rx_bit_o,
  output logic                        tx_stb_o,
  input  logic                        tx_bit_i
);
  localparam int CNT_W = $clog2(MAX_BITS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [MAX_BITS-1:0] staged;
  bsr_map_stage #(.BITS(MAX_BITS)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(map_we_i),
    .addr_i(map_addr_i), .bit_i(map_bit_i), .map_o(staged)
  );

  logic [N_DIR-1:0]    sync_v, tick_v, bnd_v;
  logic [CNT_W-1:0]    idx_v [N_DIR];
  logic [MAX_BITS-1:0] act_v [N_DIR];

  assign sync_v[DIR_RX] = rx_fs_i;
  assign sync_v[DIR_TX] = share_timing_i ? rx_fs_i : tx_fs_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    bsr_framer #(.CNT_W(CNT_W)) u_framer (
      .clk_i(clk_i), .rst_ni(rst_n), .sync_i(sync_v[d]), .last_i(frame_last_i),
      .tick_o(tick_v[d]), .idx_o(idx_v[d]), .boundary_o(bnd_v[d])
    );
    bsr_map_active #(.BITS(MAX_BITS)) u_active (
      .clk_i(clk_i), .rst_ni(rst_n), .load_i(bnd_v[d]),
      .staged_i(staged), .map_o(act_v[d])
    );
  end

  // receive path
  logic rx_sel;
  logic rx_stb_q, rx_stb_d, rx_bit_q, rx_bit_d;
  assign rx_sel = tick_v[DIR_RX] & act_v[DIR_RX][idx_v[DIR_RX]];

  always_comb begin
    rx_stb_d = rx_sel;
    rx_bit_d = rx_sel ? rxd_i : rx_bit_q;
  end

  // transmit path
  logic tx_first, tx_req;
  logic oe_q, oe_d;
  assign tx_first = ~tick_v[DIR_TX];
  assign tx_req   = tx_first & act_v[DIR_TX][idx_v[DIR_TX]];

  always_comb begin
    oe_d = oe_q;
    if (tx_first) oe_d = tx_req & ~tx_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_stb_q <= 1'b0;
      rx_bit_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      rx_stb_q <= rx_stb_d;
      rx_bit_q <= rx_bit_d;
      oe_q     <= oe_d;
    end
  end

  assign rx_stb_o = rx_stb_q;
  assign rx_bit_o = rx_bit_q;
  assign tx_stb_o = tx_req;
  assign txd_oe_o = oe_q;
  assign txd_o    = 1'b0;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rxd_i,
  input logic rx_stb_o,
  input logic rx_bit_o,
  input logic tx_stb_o,
  input logic tx_bit_i,
  input logic txd_oe_o
);
  // R3
  rx_stb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_o |=> !rx_stb_o);

  // R3
  rx_bit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_o |-> (rx_bit_o == $past(rxd_i)));

  // R4
  tx_stb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_o |=> !tx_stb_o);

  // R5
  oe_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_oe_o) |-> ($past(tx_stb_o) && !$past(tx_bit_i)));

  // R5
  oe_one_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_stb_o) && $past(tx_bit_i)) |-> !txd_oe_o);

  // R5
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_oe_o) |=> txd_oe_o);
endmodule

bind bit_slot_router bsr_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .rx_stb_o(rx_stb_o),
  .rx_bit_o(rx_bit_o), .tx_stb_o(tx_stb_o), .tx_bit_i(tx_bit_i), .txd_oe_o(txd_oe_o)
);

// File: tb/sim_bit_slot_router.sv
`timescale 1ns/1ps
module sim_bit_slot_router;
  localparam int MB = 32;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [CW-1:0] frame_last;
  logic          share_timing, rx_fs, tx_fs, rxd, map_we, map_bit, tx_bit;
  logic [CW-1:0] map_addr;
  logic          txd, txd_oe, rx_stb, rx_bit, tx_stb;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bit_slot_router #(.MAX_BITS(MB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_last_i(frame_last),
    .share_timing_i(share_timing), .rx_fs_i(rx_fs), .tx_fs_i(tx_fs),
    .rxd_i(rxd), .txd_o(txd), .txd_oe_o(txd_oe), .map_we_i(map_we),
    .map_addr_i(map_addr), .map_bit_i(map_bit), .rx_stb_o(rx_stb),
    .rx_bit_o(rx_bit), .tx_stb_o(tx_stb), .tx_bit_i(tx_bit)
  );

  typedef struct packed {
    logic [31:0] mp;
    logic [31:0] rx;
    logic [31:0] tx;
    logic [4:0]  last;
    logic        share;
    logic        txfs;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_00A5, 32'h0000_003C, 32'h0000_000F, 5'd7,  1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'h1234_5678, 32'h8001_7FFE, 5'd31, 1'b1, 1'b0},
    '{32'h0000_0401, 32'hFFFF_FBFF, 32'h0000_0000, 5'd11, 1'b1, 1'b1},
    '{32'h0000_8002, 32'h0000_8002, 32'h0000_0002, 5'd15, 1'b0, 1'b1},
    '{32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 5'd0,  1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_map(input logic [31:0] m);
    for (int i = 0; i < MB; i++) begin
      @(negedge clk);
      map_we   = 1'b1;
      map_addr = CW'(i);
      map_bit  = m[i];
    end
    @(negedge clk);
    map_we = 1'b0;
  endtask

  // Walks frames from a receive sync in cycle 0; cycle m counts from 1.
  task automatic run_frames(input logic [31:0] mp, input logic [31:0] rxp,
                            input logic [31:0] txp, input int last,
                            input bit share, input bit txfs,
                            input int wcyc, input int waddr, input string tag);
    int L = last + 1;
    int d = (!share && txfs) ? 1 : 0;
    logic [31:0] mnew = mp;
    if (wcyc > 0) mnew[waddr] = ~mp[waddr];
    @(negedge clk);
    frame_last   = CW'(last);
    share_timing = share;
    rx_fs        = 1'b1;
    rxd          = 1'b1;
    tx_bit       = 1'b1;
    for (int m = 1; m <= 4 * L + 3; m++) begin
      @(negedge clk);
      // receive side (R2, R3, frame index >= 1 exercises R6)
      if (m >= 2) begin
        if (m % 2 == 1) begin
          int n = m - 1;
          int p = ((n - 1) / 2) % L;
          logic [31:0] mm = (wcyc > 0 && (n - 1) / (2 * L) >= 1) ? mnew : mp;
          string rq = ((n - 1) / (2 * L) >= 1) ? "R6/R3" : "R2/R3";
          chk(rx_stb == mm[p], {rq, " ", tag}, $sformatf("rx_stb pos %0d", p), rx_stb, mm[p]);
          if (mm[p]) chk(rx_bit == rxp[p], {rq, " ", tag}, $sformatf("rx_bit pos %0d", p), rx_bit, rxp[p]);
        end else begin
          chk(rx_stb == 1'b0, {"R3 ", tag}, "rx_stb in first half", rx_stb, 0);
        end
      end
      // transmit side (R4, R5)
      begin
        int mt = m - d;
        tx_bit = 1'b1;
        if (mt >= 1) begin
          if (mt % 2 == 1) begin
            int p = ((mt - 1) / 2) % L;
            logic [31:0] mm = (wcyc > 0 && (mt - 1) / (2 * L) >= 1) ? mnew : mp;
            chk(tx_stb == mm[p], {"R4 ", tag}, $sformatf("tx_stb pos %0d", p), tx_stb, mm[p]);
            tx_bit = txp[p];
          end else begin
            chk(tx_stb == 1'b0, {"R4 ", tag}, "tx_stb in second half", tx_stb, 0);
          end
        end
        if (mt >= 2) begin
          int nt = (mt % 2 == 0) ? mt - 1 : mt - 2;
          int p = ((nt - 1) / 2) % L;
          logic [31:0] mm = (wcyc > 0 && (nt - 1) / (2 * L) >= 1) ? mnew : mp;
          logic e = mm[p] & ~txp[p];
          chk(txd_oe == e && txd == 1'b0, {"R5 ", tag}, $sformatf("txd_oe pos %0d", p), txd_oe, e);
        end
      end
      rx_fs    = 1'b0;
      tx_fs    = (txfs && m == 1);
      map_we   = (wcyc == m);
      map_addr = CW'(waddr);
      map_bit  = mnew[waddr];
      rxd      = rxp[((m - 1) / 2) % L];
    end
    @(negedge clk);
    map_we = 1'b0;
    tx_fs  = 1'b0;
    rxd    = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; frame_last = CW'(7); share_timing = 1'b1;
    rx_fs = 1'b0; tx_fs = 1'b0; rxd = 1'b1; map_we = 1'b0;
    map_addr = '0; map_bit = 1'b0; tx_bit = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(rx_stb == 1'b0 && tx_stb == 1'b0 && txd_oe == 1'b0, "R1", "outputs in reset",
        {rx_stb, tx_stb, txd_oe}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_stb == 1'b0 && tx_stb == 1'b0 && txd_oe == 1'b0, "R1", "outputs after reset",
        {rx_stb, tx_stb, txd_oe}, 0);
    // R1: cleared map gives no strobes
    run_frames(32'h0, 32'h0, 32'h0, 7, 1'b1, 1'b0, 0, 0, "R1 empty map");

    // vector table (R9 on entries with a transmit sync)
    for (int v = 0; v < NV; v++) begin
      load_map(VECS[v].mp);
      run_frames(VECS[v].mp, VECS[v].rx, VECS[v].tx, int'(VECS[v].last),
                 VECS[v].share, VECS[v].txfs, 0, 0,
                 VECS[v].txfs ? $sformatf("R9 vec %0d", v) : $sformatf("vec %0d", v));
    end

    // R7: previous run stopped mid-frame; a new sync restarts at position 0
    load_map(32'h0000_00C3);
    run_frames(32'h0000_00C3, 32'h0000_0055, 32'h0000_0081, 7, 1'b1, 1'b0, 0, 0, "R7 first");
    run_frames(32'h0000_00C3, 32'h0000_00AA, 32'h0000_0042, 7, 1'b1, 1'b0, 0, 0, "R7 restart");

    // R8: flip one entry mid-frame; change only from the wrap onward
    load_map(32'h0000_000F);
    run_frames(32'h0000_000F, 32'h0000_0005, 32'h0000_0002, 3, 1'b1, 1'b0, 3, 2, "R8 clear bit");
    run_frames(32'h0000_000B, 32'h0000_000A, 32'h0000_0000, 3, 1'b1, 1'b0, 2, 2, "R8 set bit");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule